// File: doc/BRIEF.md
# Byte Lane Strobe Generator

This block drives the eight active-low byte-lane strobes of a 64-bit external memory bus. On each bus-clock cycle it looks at the port width of the bank being accessed, the size of the transfer, and the three low address bits, and from them it works out which byte lanes carry valid data. Lane 0 is the most significant byte of the bus, bits D[0:7], and lane 7 is the least significant byte, bits D[56:63].

A field of the bank configuration picks one of three programmable timing engines. Each engine supplies one strobe-timing bit. The block ANDs that bit with the lane mask and registers the result, so the chosen engine alone decides when the enabled strobes go low and when they return high. A select code that names no engine keeps every strobe high. A refresh request turns on every lane, whatever the size and address inputs are. When no bus cycle is in progress, all strobes stay negated.

Top module: `byte_lane_strobe`

## Requirements
- R1: While `rst` is high at a clock edge, all bits of `bs_n` are 1 after that edge.
- R2: If `cyc_active` is 0 at an edge, `bs_n` is all ones after that edge.
- R3: `bs_n[i]` is the strobe for lane i, and lane 0 is the most significant byte. On a 64-bit port (`port_size`=00), with offset a=`addr_lo` and n bytes, lanes a through min(a+n,8)-1 are asserted (0) and all other lanes are 1.
- R4: `xfer_size` 1 to 7 means that many bytes. `xfer_size`=000 means 8 bytes.
- R5: The `port_size` codes are 00 for 64-bit, 01 for 8-bit, 10 for 16-bit and 11 for 32-bit, covering P = 8, 1, 2 or 4 lanes. On a port of P lanes, the offset is `addr_lo` mod P, and no lane numbered P or higher is ever asserted.
- R6: The enabled lanes stop at the port boundary. Lanes from offset+n up to P-1 are asserted only when they are inside the span, and the span never wraps around.
- R7: When `refresh` is 1, every lane's mask bit is 1, regardless of port size, transfer size and address.
- R8: `eng_sel` values 01, 10 and 11 choose engine 0, 1 and 2. Only `eng_timing[eng_sel-1]` gates the strobes, and the timing bits of the other engines have no effect.
- R9: When `eng_sel`=00, `bs_n` is all ones.
- R10: The strobes are registered. The value of `bs_n` after an edge is the complement of (mask AND selected timing bit), computed from the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_active | input | 1 | A bus cycle is in progress |
| refresh | input | 1 | The current cycle is a refresh-timer request |
| port_size | input | 2 | Port width code of the addressed bank |
| xfer_size | input | 3 | Transfer size in bytes (000 = 8) |
| addr_lo | input | 3 | Low three address bits |
| eng_sel | input | 2 | Timing-engine select (00 = none) |
| eng_timing | input | 3 | Current strobe-timing bit of each engine |
| bs_n | output | 8 | Active-low byte-lane strobes, bit i = lane i |

## Verification
The hardest cases to reach from the ports are transfers that cross the port boundary. These occur when the address offset inside a narrow port plus the transfer size goes past the port width, and they only clip correctly if the offset is first wrapped modulo the port width. Purely random stimulus seldom lands on the exact offset and size pairs at the edge of a 16-bit or 32-bit port, so directed cases place an access one byte before each boundary with sizes that overrun it. Random cycles then cover the remaining combinations. Other directed cases set the unselected engines' timing bits to the opposite value of the selected one, to show that they are ignored.

// File: rtl/bls_pkg.sv
package bls_pkg;
  typedef enum logic [1:0] {
    PS_WIDE = 2'b00,
    PS_BYTE = 2'b01,
    PS_HALF = 2'b10,
    PS_WORD = 2'b11
  } port_size_e;

  // Number of lanes a port of the given code connects to, limited to the bus.
  function automatic int port_lanes(input logic [1:0] code, input int lanes);
    int w;
    case (port_size_e'(code))
      PS_BYTE: w = 1;
      PS_HALF: w = 2;
      PS_WORD: w = 4;
      default: w = lanes;
    endcase
    return (w > lanes) ? lanes : w;
  endfunction
endpackage

// File: rtl/bls_lane_mask.sv
module bls_lane_mask #(
  parameter int LANES = 8,
  localparam int AW = $clog2(LANES)
) (
  input  logic [1:0]       port_size,
  input  logic [AW-1:0]    xfer_size,
  input  logic [AW-1:0]    addr_lo,
  input  logic             refresh,
  output logic [LANES-1:0] mask
);
  import bls_pkg::*;
  localparam int CW = AW + 2;

  logic [CW-1:0] pbytes, offset, nbytes, span_end, clip_end;

  always_comb begin
    pbytes   = CW'(port_lanes(port_size, LANES));
    offset   = CW'(addr_lo) & (pbytes - CW'(1));
    nbytes   = (xfer_size == '0) ? CW'(LANES) : CW'(xfer_size);
    span_end = offset + nbytes;
    clip_end = (span_end > pbytes) ? pbytes : span_end;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [CW-1:0] LIDX = CW'(i);
    assign mask[i] = refresh | ((LIDX >= offset) && (LIDX < clip_end));
  end
endmodule

// File: rtl/bls_engine_mux.sv
module bls_engine_mux #(
  parameter int ENGINES = 3,
  localparam int SW = $clog2(ENGINES + 1)
) (
  input  logic [SW-1:0]      eng_sel,
  input  logic [ENGINES-1:0] eng_timing,
  output logic               eng_valid,
  output logic               eng_strobe
);
  always_comb begin
    eng_valid  = 1'b0;
    eng_strobe = 1'b0;
    for (int e = 0; e < ENGINES; e++) begin
      if (eng_sel == SW'(e + 1)) begin
        eng_valid  = 1'b1;
        eng_strobe = eng_timing[e];
      end
    end
  end
endmodule

// File: rtl/byte_lane_strobe.sv
module byte_lane_strobe #(
  parameter int LANES   = 8,
  parameter int ENGINES = 3,
  localparam int AW = $clog2(LANES),
  localparam int SW = $clog2(ENGINES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cyc_active,
  input  logic               refresh,
  input  logic [1:0]         port_size,
  input  logic [AW-1:0]      xfer_size,
  input  logic [AW-1:0]      addr_lo,
  input  logic [SW-1:0]      eng_sel,
  input  logic [ENGINES-1:0] eng_timing,
  output logic [LANES-1:0]   bs_n
);
  logic [LANES-1:0] lane_mask;
  logic             eng_valid, eng_strobe;

  bls_lane_mask #(.LANES(LANES)) u_mask (
    .port_size(port_size), .xfer_size(xfer_size), .addr_lo(addr_lo),
    .refresh(refresh), .mask(lane_mask)
  );

  bls_engine_mux #(.ENGINES(ENGINES)) u_eng (
    .eng_sel(eng_sel), .eng_timing(eng_timing),
    .eng_valid(eng_valid), .eng_strobe(eng_strobe)
  );

  always_ff @(posedge clk) begin
    if (rst) bs_n <= '1;
    else if (cyc_active && eng_valid) bs_n <= ~(lane_mask & {LANES{eng_strobe}});
    else bs_n <= '1;
  end

  assert_idle_negated_R2: assert property (@(posedge clk) disable iff (rst)
    !cyc_active |=> (bs_n == '1));
  assert_no_engine_R9: assert property (@(posedge clk) disable iff (rst)
    (eng_sel == '0) |=> (bs_n == '1));
  assert_refresh_all_R7: assert property (@(posedge clk) disable iff (rst)
    (cyc_active && refresh && eng_valid && eng_strobe) |=> (bs_n == '0));
  assert_byte_port_R5: assert property (@(posedge clk) disable iff (rst)
    (port_size == 2'b01 && !refresh) |=> (bs_n[LANES-1:1] == '1));
  assert_half_port_R5: assert property (@(posedge clk) disable iff (rst)
    (port_size == 2'b10 && !refresh) |=> (bs_n[LANES-1:2] == '1));
  assert_timing_gate_R10: assert property (@(posedge clk) disable iff (rst)
    !eng_strobe |=> (bs_n == '1));
  assert_mask_in_span_R6: assert property (@(posedge clk) disable iff (rst)
    (!refresh && xfer_size != '0) |=> ($countones(~bs_n) <= $past(xfer_size)));
endmodule

// File: tb/byte_lane_strobe_bench.sv
module byte_lane_strobe_bench;
  logic clk = 1'b0, rst = 1'b1, cyc_active = 1'b0, refresh = 1'b0;
  logic [1:0] port_size = '0, eng_sel = '0;
  logic [2:0] xfer_size = '0, addr_lo = '0, eng_timing = '0;
  logic [7:0] bs_n;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  byte_lane_strobe u_byte_lane_strobe (
    .clk(clk), .rst(rst), .cyc_active(cyc_active), .refresh(refresh),
    .port_size(port_size), .xfer_size(xfer_size), .addr_lo(addr_lo),
    .eng_sel(eng_sel), .eng_timing(eng_timing), .bs_n(bs_n)
  );

  function automatic logic [7:0] model(input logic c, input logic rf, input logic [1:0] ps,
      input logic [2:0] xs, input logic [2:0] a, input logic [1:0] es, input logic [2:0] et);
    int p, off, n, last;
    logic [7:0] m;
    logic t;
    p = (ps == 2'b01) ? 1 : (ps == 2'b10) ? 2 : (ps == 2'b11) ? 4 : 8;
    off = int'(a) % p;
    n = (xs == 0) ? 8 : int'(xs);
    last = (off + n > p) ? p : off + n;
    for (int i = 0; i < 8; i++) m[i] = rf || (i >= off && i < last);
    t = (es == 0) ? 1'b0 : et[es - 1];
    if (!c || es == 0) return 8'hFF;
    return ~(m & {8{t}});
  endfunction

  task automatic check(input string tag, input logic [7:0] exp);
    checks++;
    if (bs_n !== exp) begin
      failures++;
      $display("FAIL %s bs_n=%b expected=%b", tag, bs_n, exp);
    end
  endtask

  task automatic cycle(input string tag, input logic c, input logic rf, input logic [1:0] ps,
      input logic [2:0] xs, input logic [2:0] a, input logic [1:0] es, input logic [2:0] et);
    @(negedge clk);
    cyc_active = c; refresh = rf; port_size = ps; xfer_size = xs;
    addr_lo = a; eng_sel = es; eng_timing = et;
    @(posedge clk); #2;
    check(tag, model(c, rf, ps, xs, a, es, et));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 check("R1", 8'hFF);
    @(negedge clk) rst = 1'b0;
    cycle("R2", 1'b0, 1'b0, 2'b00, 3'd4, 3'd0, 2'd1, 3'b111);
    cycle("R3", 1'b1, 1'b0, 2'b00, 3'd1, 3'd0, 2'd1, 3'b001);
    if (bs_n !== 8'b1111_1110) begin failures++; $display("FAIL R3 lane0 bs_n=%b expected=11111110", bs_n); end
    checks++;
    cycle("R3", 1'b1, 1'b0, 2'b00, 3'd2, 3'd6, 2'd1, 3'b001);
    cycle("R4", 1'b1, 1'b0, 2'b00, 3'd0, 3'd0, 2'd2, 3'b010);
    cycle("R6", 1'b1, 1'b0, 2'b00, 3'd4, 3'd6, 2'd1, 3'b001);
    cycle("R5", 1'b1, 1'b0, 2'b01, 3'd4, 3'd5, 2'd1, 3'b001);
    cycle("R5", 1'b1, 1'b0, 2'b10, 3'd1, 3'd7, 2'd3, 3'b100);
    cycle("R6", 1'b1, 1'b0, 2'b10, 3'd4, 3'd1, 2'd3, 3'b100);
    cycle("R6", 1'b1, 1'b0, 2'b11, 3'd3, 3'd3, 2'd1, 3'b001);
    cycle("R6", 1'b1, 1'b0, 2'b11, 3'd0, 3'd6, 2'd2, 3'b010);
    cycle("R7", 1'b1, 1'b1, 2'b01, 3'd1, 3'd5, 2'd2, 3'b010);
    cycle("R8", 1'b1, 1'b0, 2'b00, 3'd0, 3'd0, 2'd2, 3'b101);
    cycle("R8", 1'b1, 1'b0, 2'b00, 3'd0, 3'd0, 2'd3, 3'b100);
    cycle("R9", 1'b1, 1'b1, 2'b00, 3'd0, 3'd0, 2'd0, 3'b111);
    cycle("R10", 1'b1, 1'b1, 2'b00, 3'd0, 3'd0, 2'd1, 3'b000);
    void'($urandom(32'd4242));
    for (int k = 0; k < 400; k++) begin
      cycle("R10", ($urandom % 8) != 0, ($urandom % 10) == 0, 2'($urandom), 3'($urandom),
            3'($urandom), 2'($urandom), 3'($urandom));
    end
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #2 check("R1", 8'hFF);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule